// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer with Link Training

This block turns a parallel data word into a serial frame once per word period. A fast bit clock drives it. A phase counter inside the block divides that clock by the frame length, and in this way the counter stands in for the clock-multiplying loop of a real transmitter. Every frame carries a fixed high start bit, then the payload with the lowest bit first, then a fixed low stop bit. The two fixed bits give a receiver a guaranteed rising transition in each frame, and the receiver recovers its clock from it.

A receiver that has lost alignment can ask for training. It does this by raising either of two request inputs, which are ORed. A request that is held for enough word boundaries replaces the payload with a half-high, half-low training frame. The training then runs for a guaranteed minimum number of frames, and longer if the request stays high. Three further controls affect the output. A power control puts the block into a sleep state. A lock wait blanks the output after reset and after each wake-up. An output enable blanks the line without disturbing the state behind it. The output-valid signal stands for the driver being actively driven rather than floating.

Top module: `frame_serializer`

## Requirements
- R1: A frame is 12 bit clocks long, and slot j of a word period is the bit clock after the j-th rising edge of that period. Slot 0 carries a 1 (start), slots 1 to 10 carry data bits 0 to 9 in that order, and slot 11 carries a 0 (stop). A word that has been captured is sent in the frame of the following word period.
- R2: The phase-select input chooses when the parallel word is captured. When it is 1, capture happens at the word boundary (the rising edge that starts slot 0). When it is 0, capture happens at mid-word (the rising edge that starts slot 6).
- R3: After reset, the output-valid signal stays low for 510 word periods and goes high at the start of word period 510.
- R4: A training frame is 1 in slots 0 to 5 and 0 in slots 6 to 11, so its 12-bit value is 0x03F when slot 0 is taken as bit 0.
- R5: The two training request inputs are ORed. Either one alone can start and hold training.
- R6: The request is sampled at each word boundary. Payload is replaced from the frame that starts at the fifth consecutive boundary at which the request is seen high. A request that is seen at only four boundaries has no effect on the frames.
- R7: Once training starts, at least 1024 training frames are sent even if the request drops. After that, data frames resume at once when the request is low.
- R8: Training continues past 1024 frames for as long as the request stays high. It ends at the first boundary at which the request is low.
- R9: Output enable low forces output-valid low at once. Raising it again restores output-valid at once, with no new lock wait, and the frame stream carries on unchanged.
- R10: Power control low forces output-valid low and clears the lock wait, the phase counter and all training state. After power control returns high, the output stays invalid for a further 510 word periods, and then data frames resume with no training left over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 12 per word period |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Parallel payload word |
| edge_rise | input | 1 | Capture phase select: 1 = word boundary, 0 = mid-word |
| sync_a | input | 1 | Training request, first source |
| sync_b | input | 1 | Training request, second source |
| out_en | input | 1 | Serial output enable |
| pwr_on | input | 1 | Low puts the block into sleep |
| ser_out | output | 1 | Serial line data |
| ser_valid | output | 1 | Line is actively driven (low models high impedance) |

## Verification
The bench counts rising edges from the release of reset, or from the return of power control, and it reads each result on the falling edge that follows the rising edge it is due after. Slot j of word period m is due after rising edge 12m+j. A word present at the boundary edge 12m (or at the mid-word edge 12m+6 when falling-phase capture is selected) is therefore read back over edges 12(m+1) to 12(m+1)+11. A request raised before boundary n is first seen as a training frame in word n+4, and the minimum run of 1024 frames ends after word n+1027. Output-valid follows the enable and power inputs in the same cycle. The lock release is checked at word 509 (still low) and at edge 12·510 (high).

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;
   typedef enum logic {
      LNK_WAIT = 1'b0,
      LNK_LIVE = 1'b1
   } link_state_t;
endpackage

// File: rtl/fs_phase_gen.sv
module fs_phase_gen #(
   parameter int FRAME_BITS = 12,
   localparam int PW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   output logic [PW-1:0] phase,
   output logic          word_tick,
   output logic          mid_tick
);
   localparam logic [PW-1:0] LAST_P = PW'(FRAME_BITS - 1);
   localparam logic [PW-1:0] MID_P  = PW'(FRAME_BITS / 2 - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (hold) begin
         phase <= '0;
      end else if (phase == LAST_P) begin
         phase <= '0;
      end else begin
         phase <= phase + PW'(1);
      end
   end

   assign word_tick = !hold && (phase == LAST_P);
   assign mid_tick  = !hold && (phase == MID_P);
endmodule

// File: rtl/fs_link_ctrl.sv
module fs_link_ctrl
   import frame_ser_pkg::*;
#(
   parameter int LOCK_WORDS = 510,
   localparam int LW = $clog2(LOCK_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          word_tick,
   output logic          run,
   output logic [LW-1:0] lock_cnt
);
   localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_WORDS - 1);

   link_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= LNK_WAIT;
         lock_cnt <= '0;
      end else if (clr) begin
         state    <= LNK_WAIT;
         lock_cnt <= '0;
      end else if (word_tick && state == LNK_WAIT) begin
         if (lock_cnt == LOCK_LAST) begin
            state <= LNK_LIVE;
         end else begin
            lock_cnt <= lock_cnt + LW'(1);
         end
      end
   end

   assign run = (state == LNK_LIVE);
endmodule

// File: rtl/fs_sync_ctrl.sv
module fs_sync_ctrl #(
   parameter int SYNC_QUAL = 5,
   parameter int SYNC_MIN  = 1024,
   localparam int QW = $clog2(SYNC_QUAL + 1),
   localparam int SW = $clog2(SYNC_MIN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          word_tick,
   input  logic          req,
   output logic          use_sync,
   output logic          sync_mode,
   output logic [SW-1:0] sym_cnt
);
   localparam logic [QW-1:0] QUAL_P = QW'(SYNC_QUAL);
   localparam logic [SW-1:0] MIN_P  = SW'(SYNC_MIN);

   logic [QW-1:0] hi_cnt;
   logic [QW-1:0] hi_nxt;
   logic          held;

   always_comb begin
      if (!req) begin
         hi_nxt = '0;
      end else if (hi_cnt == QUAL_P) begin
         hi_nxt = hi_cnt;
      end else begin
         hi_nxt = hi_cnt + QW'(1);
      end
      held     = (hi_nxt == QUAL_P);
      use_sync = held || (sync_mode && (sym_cnt < MIN_P));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt    <= '0;
         sync_mode <= 1'b0;
         sym_cnt   <= '0;
      end else if (clr) begin
         hi_cnt    <= '0;
         sync_mode <= 1'b0;
         sym_cnt   <= '0;
      end else if (word_tick) begin
         hi_cnt    <= hi_nxt;
         sync_mode <= use_sync;
         if (!use_sync) begin
            sym_cnt <= '0;
         end else if (!sync_mode) begin
            sym_cnt <= SW'(1);
         end else if (sym_cnt != MIN_P) begin
            sym_cnt <= sym_cnt + SW'(1);
         end
      end
   end
endmodule

// File: rtl/fs_frame_path.sv
module fs_frame_path #(
   parameter int DATA_W = 10,
   localparam int FB   = DATA_W + 2,
   localparam int PW   = $clog2(FB),
   localparam int HALF = FB / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              word_tick,
   input  logic              mid_tick,
   input  logic              edge_rise,
   input  logic              use_sync,
   input  logic [DATA_W-1:0] din,
   input  logic [PW-1:0]     phase,
   output logic              ser_bit
);
   logic [DATA_W-1:0] din_q;
   logic [FB-1:0]     frame_q;
   logic [FB-1:0]     data_frame;
   logic [FB-1:0]     train_frame;
   logic              capture;

   assign data_frame[0]    = 1'b1;
   assign data_frame[FB-1] = 1'b0;

   for (genvar i = 0; i < DATA_W; i++) begin : g_payload
      assign data_frame[i+1] = din_q[i];
   end

   for (genvar k = 0; k < FB; k++) begin : g_train
      assign train_frame[k] = (k < HALF);
   end

   assign capture = edge_rise ? word_tick : mid_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din_q   <= '0;
         frame_q <= '0;
      end else if (clr) begin
         din_q   <= '0;
         frame_q <= '0;
      end else begin
         if (capture) begin
            din_q <= din;
         end
         if (word_tick) begin
            frame_q <= use_sync ? train_frame : data_frame;
         end
      end
   end

   assign ser_bit = frame_q[phase];
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
   parameter int DATA_W     = 10,
   parameter int LOCK_WORDS = 510,
   parameter int SYNC_QUAL  = 5,
   parameter int SYNC_MIN   = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              edge_rise,
   input  logic              sync_a,
   input  logic              sync_b,
   input  logic              out_en,
   input  logic              pwr_on,
   output logic              ser_out,
   output logic              ser_valid
);
   localparam int FB = DATA_W + 2;
   localparam int PW = $clog2(FB);
   localparam int LW = $clog2(LOCK_WORDS);
   localparam int SW = $clog2(SYNC_MIN + 1);

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("frame_serializer: DATA_W must be even and at least 2");
   end
   if (LOCK_WORDS < 2) begin : g_bad_lock
      $error("frame_serializer: LOCK_WORDS must be at least 2");
   end
   if (SYNC_QUAL < 1 || SYNC_MIN < 1) begin : g_bad_sync
      $error("frame_serializer: SYNC_QUAL and SYNC_MIN must be positive");
   end

   logic          clr;
   logic [PW-1:0] phase;
   logic          word_tick;
   logic          mid_tick;
   logic          run;
   logic [LW-1:0] lock_cnt;
   logic          use_sync;
   logic          sync_mode;
   logic [SW-1:0] sym_cnt;

   assign clr = !pwr_on;

   fs_phase_gen #(.FRAME_BITS(FB)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (clr),
      .phase     (phase),
      .word_tick (word_tick),
      .mid_tick  (mid_tick)
   );

   fs_link_ctrl #(.LOCK_WORDS(LOCK_WORDS)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .word_tick (word_tick),
      .run       (run),
      .lock_cnt  (lock_cnt)
   );

   fs_sync_ctrl #(.SYNC_QUAL(SYNC_QUAL), .SYNC_MIN(SYNC_MIN)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .word_tick (word_tick),
      .req       (sync_a | sync_b),
      .use_sync  (use_sync),
      .sync_mode (sync_mode),
      .sym_cnt   (sym_cnt)
   );

   fs_frame_path #(.DATA_W(DATA_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .word_tick (word_tick),
      .mid_tick  (mid_tick),
      .edge_rise (edge_rise),
      .use_sync  (use_sync),
      .din       (din),
      .phase     (phase),
      .ser_bit   (ser_out)
   );

   assign ser_valid = run & out_en & pwr_on;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
   parameter int DATA_W     = 10,
   parameter int LOCK_WORDS = 510,
   parameter int SYNC_MIN   = 1024,
   localparam int FB = DATA_W + 2,
   localparam int PW = $clog2(FB),
   localparam int LW = $clog2(LOCK_WORDS),
   localparam int SW = $clog2(SYNC_MIN + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pwr_on,
   input logic [PW-1:0] phase,
   input logic          ser_out,
   input logic          ser_valid,
   input logic          run,
   input logic [LW-1:0] lock_cnt,
   input logic          sync_mode,
   input logic [SW-1:0] sym_cnt
);
   localparam logic [PW-1:0] LAST_P    = PW'(FB - 1);
   localparam logic [PW-1:0] HALF_P    = PW'(FB / 2);
   localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_WORDS - 1);
   localparam logic [SW-1:0] MIN_P     = SW'(SYNC_MIN);

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST_P); // R1
   AST_START_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && phase == '0) |-> ser_out); // R1
   AST_STOP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && phase == LAST_P) |-> !ser_out); // R1
   AST_TRAIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && phase < HALF_P) |-> ser_out); // R4
   AST_TRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && phase >= HALF_P) |-> !ser_out); // R4
   AST_LOCK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> ($past(lock_cnt) == LOCK_LAST)); // R3
   AST_TRAIN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sync_mode) && $past(pwr_on)) |-> ($past(sym_cnt) == MIN_P)); // R7
   AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> (!run && lock_cnt == '0 && !sync_mode)); // R10
endmodule

bind frame_serializer fs_checker #(
   .DATA_W     (DATA_W),
   .LOCK_WORDS (LOCK_WORDS),
   .SYNC_MIN   (SYNC_MIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_on    (pwr_on),
   .phase     (phase),
   .ser_out   (ser_out),
   .ser_valid (ser_valid),
   .run       (run),
   .lock_cnt  (lock_cnt),
   .sync_mode (sync_mode),
   .sym_cnt   (sym_cnt)
);

// File: tb/tb_frame_serializer.sv
module tb_frame_serializer;
   localparam int CLK_PERIOD = 10;
   localparam int FB         = 12;
   localparam int LOCK       = 510;
   localparam logic [11:0] TRAIN = 12'h03F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] din = '0;
   logic       edge_rise = 1'b1;
   logic       sync_a = 1'b0;
   logic       sync_b = 1'b0;
   logic       out_en = 1'b1;
   logic       pwr_on = 1'b1;
   logic       ser_out;
   logic       ser_valid;

   int cyc = 0;
   int base = 0;
   int n_chk = 0;
   int n_bad = 0;

   frame_serializer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .edge_rise (edge_rise),
      .sync_a    (sync_a),
      .sync_b    (sync_b),
      .out_en    (out_en),
      .pwr_on    (pwr_on),
      .ser_out   (ser_out),
      .ser_valid (ser_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   function automatic logic [11:0] dframe(input logic [9:0] d);
      return {1'b0, d, 1'b1};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic goto_edge(input int k);
      while (cyc != k) @(negedge clk);
   endtask

   task automatic read_word(input int m, output logic [11:0] bits, output logic vld);
      vld = 1'b1;
      for (int j = 0; j < FB; j++) begin
         goto_edge(base + FB * m + j);
         bits[j] = ser_out;
         vld = vld & ser_valid;
      end
   endtask

   task automatic expect_word(input string tag, input int m, input logic [11:0] exp);
      logic [11:0] bits;
      logic        vld;
      read_word(m, bits, vld);
      check(tag, {20'd0, bits}, {20'd0, exp});
      check({tag, " valid"}, {31'd0, vld}, 32'd1);
   endtask

   task automatic t_reset_lock();
      goto_edge(1);
      check("R3 valid low after reset", {31'd0, ser_valid}, 32'd0);
      goto_edge(FB * LOCK - 1);
      check("R3 valid low in word 509", {31'd0, ser_valid}, 32'd0);
      goto_edge(FB * LOCK);
      check("R3 valid high at word 510", {31'd0, ser_valid}, 32'd1);
   endtask

   task automatic t_data(input int m, input logic [9:0] d);
      goto_edge(FB * m - 1);
      din = d;
      expect_word("R1 data frame", m + 1, dframe(d));
   endtask

   task automatic t_edge(input int m, input logic rise, input logic [9:0] a, input logic [9:0] b);
      goto_edge(FB * m - 1);
      edge_rise = rise;
      din = a;
      goto_edge(FB * m + 2);
      din = b;
      expect_word(rise ? "R2 boundary capture" : "R2 mid-word capture", m + 1,
                  dframe(rise ? a : b));
      edge_rise = 1'b1;
   endtask

   task automatic t_enable(input int m, input logic [9:0] d);
      goto_edge(FB * m - 1);
      din = d;
      out_en = 1'b0;
      goto_edge(FB * m + 3);
      check("R9 valid low while disabled", {31'd0, ser_valid}, 32'd0);
      goto_edge(FB * m + 11);
      out_en = 1'b1;
      expect_word("R9 stream resumes", m + 1, dframe(d));
   endtask

   task automatic t_train_min(input int n, input logic [9:0] d);
      goto_edge(FB * n - 1);
      din = d;
      sync_a = 1'b1;
      expect_word("R6 data before fifth boundary", n + 3, dframe(d));
      expect_word("R6 R4 training at fifth boundary", n + 4, TRAIN);
      sync_a = 1'b0;
      expect_word("R7 last minimum training frame", n + 1027, TRAIN);
      expect_word("R7 data after minimum run", n + 1028, dframe(d));
   endtask

   task automatic t_train_short(input int n, input logic [9:0] d);
      goto_edge(FB * n - 1);
      din = d;
      sync_b = 1'b1;
      goto_edge(FB * (n + 3) + 1);
      sync_b = 1'b0;
      expect_word("R6 short request ignored", n + 4, dframe(d));
      expect_word("R6 short request ignored later", n + 5, dframe(d));
   endtask

   task automatic t_train_long(input int n, input logic [9:0] d);
      goto_edge(FB * n - 1);
      din = d;
      sync_b = 1'b1;
      expect_word("R5 second request starts training", n + 4, TRAIN);
      expect_word("R8 training while held", n + 1030, TRAIN);
      sync_b = 1'b0;
      expect_word("R8 data after release", n + 1031, dframe(d));
   endtask

   task automatic t_sleep(input int n, input logic [9:0] d);
      logic [11:0] bits;
      logic        vld;
      goto_edge(FB * n - 1);
      din = d;
      sync_a = 1'b1;
      expect_word("R10 training before sleep", n + 4, TRAIN);
      pwr_on = 1'b0;
      goto_edge(cyc + 1);
      check("R10 valid low in sleep", {31'd0, ser_valid}, 32'd0);
      sync_a = 1'b0;
      goto_edge(cyc + 2);
      pwr_on = 1'b1;
      base = cyc;
      goto_edge(base + FB * (LOCK - 1) + 5);
      check("R10 valid low during relock", {31'd0, ser_valid}, 32'd0);
      read_word(LOCK, bits, vld);
      check("R10 valid after relock", {31'd0, vld}, 32'd1);
      check("R10 data after relock", {20'd0, bits}, {20'd0, dframe(d)});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_lock();
      t_data(511, 10'h3FF);
      t_data(513, 10'h000);
      t_data(515, 10'h155);
      t_data(517, 10'h2AA);
      t_data(519, 10'h201);
      t_edge(521, 1'b0, 10'h0F0, 10'h30C);
      t_edge(523, 1'b1, 10'h1C7, 10'h238);
      t_enable(525, 10'h36A);
      t_train_min(530, 10'h0B5);
      t_train_short(1560, 10'h2D3);
      t_train_long(1570, 10'h14E);
      t_sleep(2610, 10'h3C1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule